// File: doc/BRIEF.md
# Pointer Address Generator for a DSP Datapath

This block supplies one data-memory address per cycle from an internal pointer register, then moves that pointer according to the selected update mode. The address always carries the pointer value held before the update, so an operand fetch uses the old pointer while the new one is written back in the same cycle. This is post-modify addressing.

Five update modes share one write-back path:
- **MD_INC** steps the pointer up by one.
- **MD_DEC** steps the pointer down by one.
- **MD_OFS** adds a two's-complement offset.
- **MD_CIRC** wraps the pointer inside a power-of-two circular block. A delay line can then overwrite its oldest slot without moving any data.
- **MD_BREV** adds with the carry running from the high bit toward the low bit, inside a power-of-two FFT span. This walks the index order that a radix-2 FFT needs.

A load strobe writes an absolute pointer value. A step strobe applies the selected update.

The control flow is written as a small machine with the following state and transitions:
- **PTR_HELD** is the single pointer state.
- **T_LOAD** writes the load value.
- **T_STEP** writes the mode result.
- **T_IDLE** keeps the value.

Top module: `dsp_agu`

## Requirements
- R1: After reset, `addr_out` is 0 and `ptr_upd` reflects a step from pointer 0.
- R2: `addr_out` shows the pointer value before any update that takes place at the next clock edge.
- R3: When `ld_en` and `step_en` are both high, the pointer takes `ld_val` and the step is discarded.
- R4: Mode code 0 adds one to the pointer, and mode code 1 subtracts one. Both use 32-bit wraparound.
- R5: Mode code 2 adds `offset`, read as a two's-complement value, to the pointer.
- R6: Mode code 3 works on a block of 2^k words, where k = `circ_log2`. It replaces the low k bits with the low k bits of pointer+`offset` and keeps every higher bit. Going up past the top of the block wraps to the block base, and going down below the base wraps to the top.
- R7: Mode code 4 works on a span of 2^n words, where n = `fft_log2`. It adds `offset` into the low n bits with the carry running from bit n-1 toward bit 0 and keeps every higher bit. With `offset` = 2^(n-1), starting at an aligned base, the pointer visits base + bit-reverse(i) for steps i = 0, 1, 2, ...
- R8: With `step_en` and `ld_en` both low, the pointer holds its value. A step with mode codes 5 to 7 also leaves the pointer unchanged.
- R9: `ptr_upd` always equals the value the pointer would take if a step were applied at the next edge with the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write `ld_val` into the pointer |
| ld_val | input | 32 | Absolute pointer value |
| step_en | input | 1 | Apply the selected update to the pointer |
| mode | input | 3 | Update mode code (0 to 4; 5 to 7 hold) |
| offset | input | 32 | Signed step for modes 2, 3 and 4 |
| circ_log2 | input | 5 | log2 of the circular block size |
| fft_log2 | input | 5 | log2 of the bit-reversed span |
| addr_out | output | 32 | Issued address (pointer before update) |
| ptr_upd | output | 32 | Pointer value after a step |

## Verification
A load and a step can fall in the same cycle. The bench provokes this by raising both strobes at once, with a load value far from any value a step could produce. It judges the result from two things: `addr_out` one edge later must equal the load value, and `ptr_upd` during that cycle must still show the step result of the old pointer. The circular and bit-reversed modes are compared against sequences computed in the bench over more than two full passes of the block.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        MD_INC  = 3'd0,
        MD_DEC  = 3'd1,
        MD_OFS  = 3'd2,
        MD_CIRC = 3'd3,
        MD_BREV = 3'd4
    } agu_mode_e;

    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_LOAD = 2'd1,
        T_STEP = 2'd2
    } agu_xfer_e;

endpackage

// File: rtl/agu_linear.sv
module agu_linear
    import agu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] ptr,
    input  logic [W-1:0] offset,
    input  agu_mode_e    mode,
    output logic [W-1:0] res
);
    logic [W-1:0] delta;

    always_comb begin
        unique case (mode)
            MD_INC:  delta = W'(1);
            MD_DEC:  delta = '1;
            MD_OFS:  delta = offset;
            default: delta = '0;
        endcase
        res = ptr + delta;
    end
endmodule

// File: rtl/agu_modulo.sv
module agu_modulo #(
    parameter int W    = 32,
    parameter int SZ_W = 5
) (
    input  logic [W-1:0]    ptr,
    input  logic [W-1:0]    offset,
    input  logic [SZ_W-1:0] k,
    output logic [W-1:0]    res
);
    logic [W-1:0] mask;
    logic [W-1:0] sum;

    always_comb begin
        mask = (W'(1) << k) - W'(1);
        sum  = ptr + offset;
        res  = (ptr & ~mask) | (sum & mask);
    end

    // R6
    circ_upper_chk: assert final (((res ^ ptr) & ~mask) == '0);
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
    parameter int W    = 32,
    parameter int SZ_W = 5
) (
    input  logic [W-1:0]    ptr,
    input  logic [W-1:0]    offset,
    input  logic [SZ_W-1:0] n,
    output logic [W-1:0]    res
);
    function automatic logic [W-1:0] rev_low(input logic [W-1:0] x,
                                             input logic [SZ_W-1:0] span);
        logic [W-1:0] r;
        r = '0;
        for (int i = 0; i < W; i++) begin
            if (i < int'(span))
                r[i] = x[SZ_W'(int'(span) - 1 - i)];
        end
        return r;
    endfunction

    logic [W-1:0] mask;
    logic [W-1:0] rsum;
    logic [W-1:0] low;

    always_comb begin
        mask = (W'(1) << n) - W'(1);
        rsum = rev_low(ptr, n) + rev_low(offset, n);
        low  = rev_low(rsum, n);
        res  = (ptr & ~mask) | (low & mask);
    end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
    import agu_pkg::*;
#(
    parameter  int ADDR_W = 32,
    localparam int SZ_W   = $clog2(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              step_en,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] offset,
    input  logic [SZ_W-1:0]   circ_log2,
    input  logic [SZ_W-1:0]   fft_log2,
    output logic [ADDR_W-1:0] addr_out,
    output logic [ADDR_W-1:0] ptr_upd
);
    agu_mode_e         mode_e;
    agu_xfer_e         xfer;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] lin_res;
    logic [ADDR_W-1:0] circ_res;
    logic [ADDR_W-1:0] brev_res;

    assign mode_e = agu_mode_e'(mode);

    agu_linear #(.W(ADDR_W)) u_lin (
        .ptr(ptr_q), .offset(offset), .mode(mode_e), .res(lin_res)
    );

    agu_modulo #(.W(ADDR_W), .SZ_W(SZ_W)) u_circ (
        .ptr(ptr_q), .offset(offset), .k(circ_log2), .res(circ_res)
    );

    agu_bitrev #(.W(ADDR_W), .SZ_W(SZ_W)) u_brev (
        .ptr(ptr_q), .offset(offset), .n(fft_log2), .res(brev_res)
    );

    // Output process: mode selection and transfer decision
    always_comb begin
        unique case (mode_e)
            MD_INC, MD_DEC, MD_OFS: ptr_upd = lin_res;
            MD_CIRC:                ptr_upd = circ_res;
            MD_BREV:                ptr_upd = brev_res;
            default:                ptr_upd = ptr_q;
        endcase
        if (ld_en)        xfer = T_LOAD;
        else if (step_en) xfer = T_STEP;
        else              xfer = T_IDLE;
    end

    // State process: the pointer register (state PTR_HELD)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            unique case (xfer)
                T_LOAD:  ptr_q <= ld_val;
                T_STEP:  ptr_q <= ptr_upd;
                default: ptr_q <= ptr_q;
            endcase
        end
    end

    assign addr_out = ptr_q;

    // R3
    load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> addr_out == $past(ld_val));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !step_en) |=> $stable(addr_out));

    // R4
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !ld_en && mode == 3'd0) |=> addr_out == $past(addr_out) + ADDR_W'(1));

    // R6
    circ_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !ld_en && mode == 3'd3)
        |=> ((addr_out ^ $past(addr_out)) >> $past(circ_log2)) == '0);

    // R7
    brev_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !ld_en && mode == 3'd4)
        |=> ((addr_out ^ $past(addr_out)) >> $past(fft_log2)) == '0);
endmodule

// File: tb/sim_dsp_agu.sv
module sim_dsp_agu;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_val = '0;
    logic        step_en = 1'b0;
    logic [2:0]  mode = '0;
    logic [31:0] offset = '0;
    logic [4:0]  circ_log2 = '0;
    logic [4:0]  fft_log2 = '0;
    logic [31:0] addr_out;
    logic [31:0] ptr_upd;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    dsp_agu u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
        .step_en(step_en), .mode(mode), .offset(offset),
        .circ_log2(circ_log2), .fft_log2(fft_log2),
        .addr_out(addr_out), .ptr_upd(ptr_upd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at the falling edge, let the register update at the rising edge
    task automatic cyc(input logic ld, input logic [31:0] lv, input logic st,
                       input logic [2:0] md, input logic [31:0] off);
        @(negedge clk);
        ld_en = ld; ld_val = lv; step_en = st; mode = md; offset = off;
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [31:0] v);
        cyc(1'b1, v, 1'b0, 3'd0, 32'd0);
        cyc(1'b0, 32'd0, 1'b0, 3'd0, 32'd0);
    endtask

    task automatic t_reset;
        check("R1", addr_out, 32'd0);
        @(negedge clk); mode = 3'd0; #1;
        check("R1", ptr_upd, 32'd1);
    endtask

    task automatic t_linear;
        load(32'h0000_0010);
        @(negedge clk); mode = 3'd0; step_en = 1'b1; #1;
        check("R9", ptr_upd, 32'h11);
        check("R2", addr_out, 32'h10);
        @(posedge clk); #1;
        check("R4", addr_out, 32'h11);
        cyc(1'b0, 0, 1'b1, 3'd1, 0);
        cyc(1'b0, 0, 1'b1, 3'd1, 0);
        check("R4", addr_out, 32'h0F);
        load(32'h0);
        cyc(1'b0, 0, 1'b1, 3'd1, 0);
        check("R4", addr_out, 32'hFFFF_FFFF);
    endtask

    task automatic t_offset;
        load(32'h0000_1000);
        cyc(1'b0, 0, 1'b1, 3'd2, 32'd8);
        check("R5", addr_out, 32'h1008);
        cyc(1'b0, 0, 1'b1, 3'd2, -32'sd24);
        check("R5", addr_out, 32'h0FF0);
    endtask

    task automatic t_load_prio;
        load(32'h0000_0040);
        @(negedge clk);
        ld_en = 1'b1; ld_val = 32'hABCD_0000; step_en = 1'b1; mode = 3'd2; offset = 32'd4; #1;
        check("R9", ptr_upd, 32'h44);
        @(posedge clk); #1;
        check("R3", addr_out, 32'hABCD_0000);
    endtask

    task automatic t_modulo(input int start, input int off, input int steps);
        int idx;
        logic [31:0] base;
        base = 32'h0000_0104;
        idx = start;
        circ_log2 = 5'd2;
        load(base + 32'(start));
        for (int i = 0; i < steps; i++) begin
            cyc(1'b0, 0, 1'b1, 3'd3, 32'(off));
            idx = (((idx + off) % 4) + 4) % 4;
            check("R6", addr_out, base + 32'(idx));
        end
    endtask

    task automatic t_bitrev;
        logic [31:0] base;
        logic [2:0]  i3;
        base = 32'h0000_0A00;
        fft_log2 = 5'd3;
        load(base);
        for (int i = 1; i <= 16; i++) begin
            cyc(1'b0, 0, 1'b1, 3'd4, 32'd4);
            i3 = 3'(i % 8);
            check("R7", addr_out, base + {29'd0, i3[0], i3[1], i3[2]});
        end
    endtask

    task automatic t_hold;
        load(32'h0000_0777);
        cyc(1'b0, 0, 1'b0, 3'd0, 32'd5);
        check("R8", addr_out, 32'h777);
        cyc(1'b0, 0, 1'b1, 3'd5, 32'd5);
        check("R8", addr_out, 32'h777);
        cyc(1'b0, 0, 1'b1, 3'd7, 32'd5);
        check("R8", addr_out, 32'h777);
    endtask

    initial begin
        #(CLK_NS * 3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_linear();
        t_offset();
        t_load_prio();
        t_modulo(2, 1, 10);
        t_modulo(1, -1, 10);
        t_modulo(0, 3, 9);
        t_bitrev();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 50000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule